// File: doc/BRIEF.md
# Staged Main Control Decoder with Bubble Insertion

This block turns the 6-bit major opcode of the instruction now in the decode stage into the nine main control bits of a five-stage integer pipeline. The bits are sorted by the stage that consumes them. The execute group holds the destination-select bit, the 2-bit ALU mode and the immediate-select bit. The memory group holds the branch, read-enable and write-enable bits. The write-back group holds the memory-to-register select and the register write enable. Each group is carried with its instruction through the decode/execute, execute/memory and memory/write-back control registers. A group is dropped once its stage has used it.

Two flush inputs, one for the decode stage and one for the execute stage, replace the control bits that enter the next register with zeros. This turns the instruction in that stage into a bubble. The ALU zero flag is captured alongside the memory group. When a branch reaches the memory stage with that flag set, the block asserts a redirect request. Operand registers, hazard detection, forwarding and exception-cause logic belong to neighbouring blocks.

Top module: `pipe_ctl_top`

## Requirements
- R1: A synchronous active-low reset clears all three control registers, so every control output and the redirect output read 0 after a clock edge with `rst_n` low.
- R2: Opcode 0 (register format) appears on the execute outputs one cycle after decode as dst_rd=1, alu_mode=2'b10, imm_sel=0. Its memory group is 0/0/0 and its write-back group is from_mem=0, reg_we=1.
- R3: Opcode 35 (load) decodes to dst_rd=0, alu_mode=2'b00, imm_sel=1, branch=0, rd_en=1, wr_en=0, from_mem=1, reg_we=1.
- R4: Opcode 43 (store) decodes to alu_mode=2'b00, imm_sel=1, branch=0, rd_en=0, wr_en=1, reg_we=0. The don't-care bits dst_rd and from_mem are driven 0.
- R5: Opcode 4 (branch if equal) decodes to alu_mode=2'b01, imm_sel=0, branch=1, rd_en=0, wr_en=0, reg_we=0, with dst_rd=0 and from_mem=0.
- R6: Any other opcode decodes to all-zero control, the same as a bubble.
- R7: The memory group of an instruction appears on the memory outputs two cycles after decode. Its write-back group appears on the write-back outputs three cycles after decode. The execute group is not kept past the execute stage.
- R8: When `flush_id_i` is high, the instruction in decode enters the execute stage as all-zero control and stays a bubble in every later stage.
- R9: When `flush_ex_i` is high, the memory and write-back groups of the instruction in execute enter the memory stage as zero. The zero flag taken at that edge is also cleared.
- R10: `take_branch_o` is high exactly while the memory-stage branch bit is 1 and the ALU zero flag, sampled on the edge that moved that instruction from execute to memory, was 1.
- R11: The control registers have no load enable. A new opcode is taken on every clock edge, so back-to-back instructions move one stage per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode_i | input | 6 | Major opcode of the instruction in decode |
| flush_id_i | input | 1 | Turns the decode-stage instruction into a bubble |
| flush_ex_i | input | 1 | Turns the execute-stage instruction into a bubble for the later stages |
| alu_zero_i | input | 1 | ALU zero flag of the instruction in execute |
| ex_dst_rd_o | output | 1 | Execute: destination register taken from the rd field |
| ex_alu_mode_o | output | 2 | Execute: ALU mode for the ALU control decoder |
| ex_imm_sel_o | output | 1 | Execute: second ALU operand is the sign-extended immediate |
| mem_branch_o | output | 1 | Memory: instruction is a conditional branch |
| mem_rd_en_o | output | 1 | Memory: data memory read |
| mem_wr_en_o | output | 1 | Memory: data memory write |
| wb_from_mem_o | output | 1 | Write-back: value comes from data memory |
| wb_reg_we_o | output | 1 | Write-back: register file write enable |
| take_branch_o | output | 1 | Memory: fetch is redirected to the branch target |

## Verification
The hardest case to reach is an execute-stage flush that hits a branch that would otherwise be taken. The bench must line up a branch-if-equal opcode, then one cycle later raise both `flush_ex_i` and `alu_zero_i` on the same edge. If the flush does not clear both the branch bit and the captured flag, a spurious redirect shows up in the following cycle. The stimulus also places a decode flush directly ahead of a load. It runs long back-to-back opcode streams and applies a reset in mid-stream. These show that bubbles and real instructions never swap groups between stages.

// File: rtl/pctl_pkg.sv
// Package: shared opcode values and per-stage control group types.
// Assumes a 6-bit major opcode; field order inside each struct is local.
package pctl_pkg;

    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_RFMT  = 6'd0;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;

    localparam int ALU_MODE_W = 2;

    localparam logic [ALU_MODE_W-1:0] ALU_MODE_ADD  = 2'b00;
    localparam logic [ALU_MODE_W-1:0] ALU_MODE_SUB  = 2'b01;
    localparam logic [ALU_MODE_W-1:0] ALU_MODE_FUNC = 2'b10;

    typedef struct packed {
        logic                  dst_rd;
        logic [ALU_MODE_W-1:0] alu_mode;
        logic                  imm_sel;
    } ex_grp_t;

    typedef struct packed {
        logic branch;
        logic rd_en;
        logic wr_en;
    } mem_grp_t;

    typedef struct packed {
        logic from_mem;
        logic reg_we;
    } wb_grp_t;

    typedef struct packed {
        ex_grp_t  ex;
        mem_grp_t mem;
        wb_grp_t  wb;
    } idex_ctl_t;

    typedef struct packed {
        mem_grp_t mem;
        wb_grp_t  wb;
        logic     zero;
    } exmem_ctl_t;

endpackage

// File: rtl/op_decoder.sv
// Module: op_decoder
// Purely combinational main decoder. It maps the decode-stage opcode onto the
// three per-stage control groups. Assumes don't-care bits are driven 0 and
// any opcode outside the supported set yields an all-zero (bubble) word.
module op_decoder
    import pctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output idex_ctl_t        ctl
);

    // Opcode to control-word table.
    always_comb begin
        ctl = '0;
        unique case (opcode)
            OPC_RFMT: begin
                ctl.ex.dst_rd   = 1'b1;
                ctl.ex.alu_mode = ALU_MODE_FUNC;
                ctl.wb.reg_we   = 1'b1;
            end
            OPC_LOAD: begin
                ctl.ex.alu_mode = ALU_MODE_ADD;
                ctl.ex.imm_sel  = 1'b1;
                ctl.mem.rd_en   = 1'b1;
                ctl.wb.from_mem = 1'b1;
                ctl.wb.reg_we   = 1'b1;
            end
            OPC_STORE: begin
                ctl.ex.alu_mode = ALU_MODE_ADD;
                ctl.ex.imm_sel  = 1'b1;
                ctl.mem.wr_en   = 1'b1;
            end
            OPC_BEQ: begin
                ctl.ex.alu_mode = ALU_MODE_SUB;
                ctl.mem.branch  = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/flush_reg.sv
// Module: flush_reg
// One pipeline control register of width W. It loads on every edge with no
// enable. A synchronous active-low reset or a high flush loads zeros, which
// forms a bubble. Assumes flush is already aligned to the loading edge.
module flush_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Register with reset/flush to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R8 / R9: a flush always leaves an all-zero word one edge later.
    p_flush_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q == '0));

    // R11: without a flush the register follows its input every edge.
    p_load_every_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (q == $past(d)));

endmodule

// File: rtl/pipe_ctl_top.sv
// Module: pipe_ctl_top
// Main control for a five-stage pipeline. The decoder output is split into
// execute, memory and write-back groups that move through three control
// registers. Decode and execute flushes zero what enters the next register.
// The branch redirect is formed from the memory-stage branch bit and the
// zero flag captured with it. Assumes alu_zero_i belongs to the instruction
// currently in execute.
module pipe_ctl_top
    import pctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OPC_W-1:0]      opcode_i,
    input  logic                  flush_id_i,
    input  logic                  flush_ex_i,
    input  logic                  alu_zero_i,
    output logic                  ex_dst_rd_o,
    output logic [ALU_MODE_W-1:0] ex_alu_mode_o,
    output logic                  ex_imm_sel_o,
    output logic                  mem_branch_o,
    output logic                  mem_rd_en_o,
    output logic                  mem_wr_en_o,
    output logic                  wb_from_mem_o,
    output logic                  wb_reg_we_o,
    output logic                  take_branch_o
);

    localparam int IDEX_W  = $bits(idex_ctl_t);
    localparam int EXMEM_W = $bits(exmem_ctl_t);
    localparam int MEMWB_W = $bits(wb_grp_t);

    idex_ctl_t  dec_ctl;
    idex_ctl_t  idex_q;
    exmem_ctl_t exmem_d;
    exmem_ctl_t exmem_q;
    wb_grp_t    memwb_q;
    logic [IDEX_W-1:0]  idex_raw;
    logic [EXMEM_W-1:0] exmem_raw;
    logic [MEMWB_W-1:0] memwb_raw;

    op_decoder u_dec (
        .opcode (opcode_i),
        .ctl    (dec_ctl)
    );

    // Decode -> execute control register.
    flush_reg #(.W(IDEX_W)) u_idex (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_id_i),
        .d     (dec_ctl),
        .q     (idex_raw)
    );
    assign idex_q = idex_ctl_t'(idex_raw);

    // Bundle the groups that move past execute, plus the zero flag.
    always_comb begin
        exmem_d.mem  = idex_q.mem;
        exmem_d.wb   = idex_q.wb;
        exmem_d.zero = alu_zero_i;
    end

    // Execute -> memory control register.
    flush_reg #(.W(EXMEM_W)) u_exmem (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush_ex_i),
        .d     (exmem_d),
        .q     (exmem_raw)
    );
    assign exmem_q = exmem_ctl_t'(exmem_raw);

    // Memory -> write-back control register (never flushed).
    flush_reg #(.W(MEMWB_W)) u_memwb (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (1'b0),
        .d     (exmem_q.wb),
        .q     (memwb_raw)
    );
    assign memwb_q = wb_grp_t'(memwb_raw);

    // Drive the stage outputs from their own register.
    always_comb begin
        ex_dst_rd_o   = idex_q.ex.dst_rd;
        ex_alu_mode_o = idex_q.ex.alu_mode;
        ex_imm_sel_o  = idex_q.ex.imm_sel;
        mem_branch_o  = exmem_q.mem.branch;
        mem_rd_en_o   = exmem_q.mem.rd_en;
        mem_wr_en_o   = exmem_q.mem.wr_en;
        wb_from_mem_o = memwb_q.from_mem;
        wb_reg_we_o   = memwb_q.reg_we;
    end

    // Branch redirect for the memory stage.
    assign take_branch_o = exmem_q.mem.branch & exmem_q.zero;

    // R7: the memory group seen now is the one execute held one edge ago.
    p_mem_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_ex_i |=> ({mem_branch_o, mem_rd_en_o, mem_wr_en_o} == $past(idex_q.mem)));

    // R7: the write-back outputs trail the memory-stage group by one edge.
    p_wb_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({wb_from_mem_o, wb_reg_we_o} == $past(exmem_q.wb)));

    // R10: a redirect needs a zero flag on the previous edge and a branch now.
    p_take_needs_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        take_branch_o |-> ($past(alu_zero_i) && mem_branch_o));

    // R4: memory read and write are never requested together.
    p_mem_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en_o && mem_wr_en_o));

    // R3: only loads select memory data, and loads always write a register.
    p_from_mem_we_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wb_from_mem_o |-> wb_reg_we_o);

endmodule

// File: tb/test_pipe_ctl_top.sv
// Bench: the driver task updates a stage model and pushes the expected
// output word; a monitor pops and compares it after each rising edge.
module test_pipe_ctl_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode_i = 6'd0;
    logic       flush_id_i = 1'b0;
    logic       flush_ex_i = 1'b0;
    logic       alu_zero_i = 1'b0;
    logic       ex_dst_rd_o;
    logic [1:0] ex_alu_mode_o;
    logic       ex_imm_sel_o;
    logic       mem_branch_o;
    logic       mem_rd_en_o;
    logic       mem_wr_en_o;
    logic       wb_from_mem_o;
    logic       wb_reg_we_o;
    logic       take_branch_o;

    typedef struct {
        logic [9:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [8:0] m_idex  = '0;   // {dst,alu[1:0],imm,br,rd,wr,fm,we}
    logic [5:0] m_exmem = '0;   // {br,rd,wr,fm,we,zero}
    logic [1:0] m_wb    = '0;   // {fm,we}

    always #4 clk = ~clk;       // 125 MHz

    pipe_ctl_top i_pipe_ctl_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .opcode_i      (opcode_i),
        .flush_id_i    (flush_id_i),
        .flush_ex_i    (flush_ex_i),
        .alu_zero_i    (alu_zero_i),
        .ex_dst_rd_o   (ex_dst_rd_o),
        .ex_alu_mode_o (ex_alu_mode_o),
        .ex_imm_sel_o  (ex_imm_sel_o),
        .mem_branch_o  (mem_branch_o),
        .mem_rd_en_o   (mem_rd_en_o),
        .mem_wr_en_o   (mem_wr_en_o),
        .wb_from_mem_o (wb_from_mem_o),
        .wb_reg_we_o   (wb_reg_we_o),
        .take_branch_o (take_branch_o)
    );

    // Expected decode per R2..R6.
    function automatic logic [8:0] spec_dec(input logic [5:0] op);
        case (op)
            6'd0:    return 9'b1_10_0_000_01;
            6'd35:   return 9'b0_00_1_010_11;
            6'd43:   return 9'b0_00_1_001_00;
            6'd4:    return 9'b0_01_0_100_00;
            default: return 9'b0;
        endcase
    endfunction

    task automatic step(input logic rst, input logic [5:0] op, input logic fid,
                        input logic fex, input logic z, input string tag);
        item_t it;
        @(negedge clk);
        rst_n      = rst;
        opcode_i   = op;
        flush_id_i = fid;
        flush_ex_i = fex;
        alu_zero_i = z;
        if (!rst) begin
            m_idex = '0; m_exmem = '0; m_wb = '0;
        end else begin
            m_wb    = m_exmem[2:1];
            m_exmem = fex ? 6'b0 : {m_idex[4:0], z};
            m_idex  = fid ? 9'b0 : spec_dec(op);
        end
        it.exp = {m_idex[8:5], m_exmem[5:3], m_wb, m_exmem[5] & m_exmem[0]};
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                logic [9:0] act;
                it  = q.pop_front();
                act = {ex_dst_rd_o, ex_alu_mode_o, ex_imm_sel_o, mem_branch_o,
                       mem_rd_en_o, mem_wr_en_o, wb_from_mem_o, wb_reg_we_o,
                       take_branch_o};
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Driver.
    initial begin
        logic [5:0] ops [12];
        ops = '{6'd0, 6'd35, 6'd43, 6'd4, 6'd0, 6'd0, 6'd35, 6'd63,
                6'd5, 6'd43, 6'd36, 6'd4};
        step(0, 6'd0,  0, 0, 0, "R1 reset");
        step(0, 6'd35, 0, 0, 1, "R1 reset");
        step(1, 6'd0,  0, 0, 0, "R2 rfmt");
        step(1, 6'd35, 0, 0, 0, "R3 load");
        step(1, 6'd43, 0, 0, 0, "R4 store");
        step(1, 6'd4,  0, 0, 0, "R5 beq R7");
        step(1, 6'd2,  0, 0, 1, "R10 zero set");
        step(1, 6'd63, 0, 0, 0, "R6 unknown R10 taken");
        step(1, 6'd4,  0, 0, 0, "R5 R7");
        step(1, 6'd0,  0, 0, 0, "R10 zero clear");
        step(1, 6'd35, 1, 0, 1, "R8 flush decode");
        step(1, 6'd35, 0, 0, 0, "R8 bubble");
        step(1, 6'd0,  0, 1, 0, "R9 flush exec");
        step(1, 6'd4,  0, 0, 0, "R9 bubble");
        step(1, 6'd43, 0, 1, 1, "R9 flushed branch");
        step(1, 6'd0,  0, 0, 1, "R9 R10 no take");
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 12; i++) begin
                step(1, ops[i], (r == 1) && (i == 5), (r == 2) && (i == 7),
                     i[0] ^ r[0], "R11 stream");
            end
        end
        step(0, 6'd35, 0, 0, 0, "R1 mid reset");
        step(1, 6'd35, 0, 0, 0, "R1 after reset");
        for (int i = 0; i < 4; i++) begin
            step(1, 6'd1, 0, 0, 0, "R6 R7 drain");
        end
        wait (q.size() == 0);
        @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule